// File: doc/BRIEF.md
# Iota Round-Constant Generator

This block supplies the 64-bit round constant that the iota step of the SHA-3 permutation (Keccak-f with 1600-bit state) XORs into lane zero, one constant per round for all 24 rounds. It keeps no constant table. A degree-8 linear feedback shift register runs through its sequence one step per clock, and each step's low bit is routed into a sparse 64-bit word. Seven steps fill one constant. The register is loaded only once per permutation, because the step index runs on without a break from one round to the next.

A consumer pulses `start_i` to begin a permutation. It then waits for `rc_valid_o`, uses `rc_o` together with `rnd_o`, and pulses `ack_i` to ask for the next round. When the last round has been acknowledged the block goes quiet until the next start.

Top module: `iota_rc_gen`

## Requirements
- R1: After reset, `rc_valid_o` is 0, `rc_o` is all zeros and `rnd_o` is 0.
- R2: The constant for round r is built from bits rc(7r+j), j = 0..6, and bit rc(j) goes to position 2^j−1, that is positions 0, 1, 3, 7, 15, 31 and 63. Every other bit is zero. rc(t) is bit 0 of an 8-bit register after t steps. The register starts at 0x01, and each step shifts it left by one and XORs the low byte with 0x71 when the bit shifted out was 1. For example round 0 gives 0x1, round 1 gives 0x8082, round 2 gives 0x800000000000808A, round 5 gives 0x80000001, round 8 gives 0x8A and round 23 gives 0x8000000080008008.
- R3: `rc_valid_o` rises on the 7th rising edge after the edge that samples `start_i`, and the constant for round 0 is then present.
- R4: While `rc_valid_o` is 1 and neither `ack_i` nor `start_i` is sampled, `rc_valid_o`, `rc_o` and `rnd_o` do not change.
- R5: An `ack_i` sampled with `rc_valid_o` high in rounds 0..22 drops `rc_valid_o` at that edge and raises `rnd_o` by one. The next constant becomes valid 7 edges later, and the register continues from where it stopped with no reload.
- R6: An `ack_i` of round 23 ends the permutation. `rc_valid_o` then stays 0, `rnd_o` stays at 23, and further `ack_i` pulses have no effect until `start_i`.
- R7: A sampled `start_i` restarts from round 0 with the register at 0x01 in any state, including mid-computation. When `start_i` and `ack_i` are sampled together, the start wins.
- R8: `ack_i` sampled while `rc_valid_o` is 0 is ignored, and the timing and the round index are unchanged.
- R9: `rc_o` reads all zeros whenever `rc_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new permutation at round 0 |
| ack_i | input | 1 | Consumer has taken the current constant, advance |
| rnd_o | output | 5 | Index of the round the constant belongs to |
| rc_o | output | 64 | Round constant, zero when not valid |
| rc_valid_o | output | 1 | Constant on `rc_o` is complete |

## Verification
Two functions can meet in one cycle: the restart driven by `start_i` and the round advance driven by `ack_i`. The bench raises both on the same edge while a constant is on display, then checks that the round index returns to 0 rather than stepping forward. It also checks that the next constant shows up after seven edges with the round 0 value. A second case lands `start_i` in the middle of the seven-step fill, and `ack_i` is also pulsed during fills, so the bench can confirm that the fill neither ends early nor skips a round.

// File: rtl/iota_rc_pkg.sv
package iota_rc_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_FILL = 2'd1,
      SEQ_SHOW = 2'd2
   } seq_state_e;

   function automatic int unsigned spread_pos(input int unsigned j);
      return (32'd1 << j) - 32'd1;
   endfunction
endpackage

// File: rtl/iota_rc_lfsr.sv
module iota_rc_lfsr #(
   parameter int unsigned         SR_W  = 8,
   parameter logic [SR_W-1:0]     TAPS  = 8'h71,
   parameter logic [SR_W-1:0]     SEED  = 8'h01
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   output logic            bit_o
);
   logic [SR_W-1:0] sr_q;
   logic [SR_W-1:0] sr_next;

   generate
      if (SR_W < 2) begin : g_bad_w
         $error("iota_rc_lfsr: SR_W must be at least 2");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("iota_rc_lfsr: SEED must be nonzero");
      end
   endgenerate

   always_comb begin
      sr_next = {sr_q[SR_W-2:0], 1'b0};
      if (sr_q[SR_W-1]) sr_next = sr_next ^ TAPS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= SEED;
      else if (load_i)  sr_q <= SEED;
      else if (step_i)  sr_q <= sr_next;
   end

   assign bit_o = sr_q[0];

   // R2: the register never falls into the all-zero lockup state
   a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sr_q != '0);

   // R7: a load always leaves the seed behind
   a_r7_seed_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> sr_q == SEED);
endmodule

// File: rtl/iota_rc_spread.sv
module iota_rc_spread #(
   parameter int unsigned LANE_W = 64,
   parameter int unsigned NBITS  = 7,
   localparam int unsigned IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              bit_i,
   output logic [LANE_W-1:0] lane_o
);
   import iota_rc_pkg::*;

   logic [NBITS-1:0] pat_q;

   generate
      if (LANE_W != (1 << (NBITS - 1))) begin : g_bad_cfg
         $error("iota_rc_spread: LANE_W must equal 2**(NBITS-1)");
      end
      for (genvar j = 0; j < NBITS; j++) begin : g_pat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pat_q[j] <= 1'b0;
            else if (wr_i && idx_i == IDX_W'(j))     pat_q[j] <= bit_i;
         end
      end
   endgenerate

   always_comb begin
      lane_o = '0;
      for (int unsigned j = 0; j < NBITS; j++) begin
         lane_o[spread_pos(j)] = pat_q[j];
      end
   end

   // R2: no more set bits than pattern bits
   a_r2_sparse: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_o) <= NBITS);
endmodule

// File: rtl/iota_rc_seq.sv
module iota_rc_seq #(
   parameter int unsigned ROUNDS = 24,
   parameter int unsigned NBITS  = 7,
   localparam int unsigned IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1,
   localparam int unsigned RND_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ack_i,
   output logic             load_o,
   output logic             step_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [RND_W-1:0] rnd_o,
   output logic             valid_o
);
   import iota_rc_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);
   localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

   seq_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic [RND_W-1:0] rnd_q;

   generate
      if (ROUNDS < 1) begin : g_bad_rounds
         $error("iota_rc_seq: ROUNDS must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         idx_q <= '0;
         rnd_q <= '0;
      end else if (start_i) begin
         st_q  <= SEQ_FILL;
         idx_q <= '0;
         rnd_q <= '0;
      end else begin
         unique case (st_q)
            SEQ_FILL: begin
               if (idx_q == LAST_IDX) st_q  <= SEQ_SHOW;
               else                   idx_q <= idx_q + 1'b1;
            end
            SEQ_SHOW: begin
               if (ack_i) begin
                  if (rnd_q == LAST_RND) begin
                     st_q <= SEQ_IDLE;
                  end else begin
                     st_q  <= SEQ_FILL;
                     idx_q <= '0;
                     rnd_q <= rnd_q + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign load_o  = start_i;
   assign step_o  = (st_q == SEQ_FILL) && !start_i;
   assign idx_o   = idx_q;
   assign rnd_o   = rnd_q;
   assign valid_o = (st_q == SEQ_SHOW);

   // R3: a constant is only shown once the final pattern slot was filled
   a_r3_full_before_show: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> idx_q == LAST_IDX);

   // R5: acknowledgement of a non-final round moves to the next index
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ack_i && !start_i && rnd_q != LAST_RND)
      |=> (!valid_o && rnd_q == RND_W'($past(rnd_q) + 1'b1)));

   // R6: the round index stays in range
   a_r6_round_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_q <= LAST_RND);

   // R7: start wins over everything
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!valid_o && rnd_q == '0 && idx_q == '0));

   // R8: acknowledgement with nothing shown changes no round
   a_r8_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !start_i) |=> $stable(rnd_q));
endmodule

// File: rtl/iota_rc_gen.sv
module iota_rc_gen #(
   parameter int unsigned      LANE_W = 64,
   parameter int unsigned      ROUNDS = 24,
   parameter int unsigned      SR_W   = 8,
   parameter logic [SR_W-1:0]  TAPS   = 8'h71,
   localparam int unsigned     NBITS  = $clog2(LANE_W) + 1,
   localparam int unsigned     IDX_W  = (NBITS > 1) ? $clog2(NBITS) : 1,
   localparam int unsigned     RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ack_i,
   output logic [RND_W-1:0]  rnd_o,
   output logic [LANE_W-1:0] rc_o,
   output logic              rc_valid_o
);
   logic             load_w;
   logic             step_w;
   logic [IDX_W-1:0] idx_w;
   logic             bit_w;
   logic [LANE_W-1:0] lane_w;
   logic             valid_w;

   generate
      if ((LANE_W & (LANE_W - 1)) != 0 || LANE_W < 2) begin : g_bad_lane
         $error("iota_rc_gen: LANE_W must be a power of two");
      end
   endgenerate

   iota_rc_seq #(.ROUNDS(ROUNDS), .NBITS(NBITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
      .load_o(load_w), .step_o(step_w), .idx_o(idx_w),
      .rnd_o(rnd_o), .valid_o(valid_w)
   );

   iota_rc_lfsr #(.SR_W(SR_W), .TAPS(TAPS), .SEED(SR_W'(1))) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
      .bit_o(bit_w)
   );

   iota_rc_spread #(.LANE_W(LANE_W), .NBITS(NBITS)) u_spread (
      .clk(clk), .rst_n(rst_n), .wr_i(step_w), .idx_i(idx_w),
      .bit_i(bit_w), .lane_o(lane_w)
   );

   assign rc_valid_o = valid_w;
   assign rc_o       = valid_w ? lane_w : '0;

   // R4: a shown constant is held until taken
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_valid_o && !ack_i && !start_i)
      |=> (rc_valid_o && $stable(rc_o) && $stable(rnd_o)));

   // R9: output is clean whenever nothing is shown
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!rc_valid_o) |-> $countones(rc_o) == 0);
endmodule

// File: tb/iota_rc_gen_tb.sv
module iota_rc_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        ack_i = 1'b0;
   logic [4:0]  rnd_o;
   logic [63:0] rc_o;
   logic        rc_valid_o;

   int cmp = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   iota_rc_gen u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i),
      .rnd_o(rnd_o), .rc_o(rc_o), .rc_valid_o(rc_valid_o)
   );

   function automatic logic [63:0] gold(input int r);
      logic [7:0]  s = 8'h01;
      logic [63:0] c = '0;
      for (int t = 0; t <= 7*r + 6; t++) begin
         if (t >= 7*r) c[(1 << (t - 7*r)) - 1] = s[0];
         s = {s[6:0], 1'b0} ^ (s[7] ? 8'h71 : 8'h00);
      end
      return c;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      cmp++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
      end
   endtask

   task automatic wait_valid(output int n);
      n = 0;
      while (!rc_valid_o && n < 40) begin
         tick();
         n++;
      end
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
   endtask

   task automatic pulse_ack();
      ack_i = 1'b1;
      tick();
      ack_i = 1'b0;
   endtask

   initial begin
      #(20ns * 100000);
      if (!finished) begin
         cmp++;
         bad++;
         $display("FAIL watchdog actual=hang expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
         $finish;
      end
   end

   initial begin
      int n;
      logic [63:0] held;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state
      chk(rc_valid_o == 1'b0, "R1 valid", 64'(rc_valid_o), 64'd0);
      chk(rc_o == '0, "R1 const", rc_o, 64'd0);
      chk(rnd_o == 5'd0, "R1 round", 64'(rnd_o), 64'd0);
      // R8: acknowledgement before any start does nothing
      pulse_ack();
      repeat (8) tick();
      chk(!rc_valid_o && rnd_o == 0, "R8 idle ack", 64'(rc_valid_o), 64'd0);

      // Full sweep of all rounds
      pulse_start();
      for (int r = 0; r < 24; r++) begin
         n = 0;
         while (!rc_valid_o && n < 40) begin
            ack_i = (r % 4 == 1 && n == 2);
            tick();
            n++;
            if (n == 3 && !rc_valid_o) begin
               // R9: zero while filling
               chk(rc_o == '0, "R9 zero while filling", rc_o, 64'd0);
            end
         end
         ack_i = 1'b0;
         // R3 / R5 / R8: seven edges per constant
         chk(n == 7, (r == 0) ? "R3 latency" :
             ((r % 4 == 1) ? "R8 latency with stray ack" : "R5 latency"),
             64'(n), 64'd7);
         chk(rc_o == gold(r), $sformatf("R2 round %0d", r), rc_o, gold(r));
         chk(rnd_o == 5'(r), "R5 round index", 64'(rnd_o), 64'(r));
         held = rc_o;
         repeat (r % 3) tick();
         chk(rc_valid_o && rc_o == held, "R4 hold", rc_o, held);
         pulse_ack();
         if (r < 23)
            chk(!rc_valid_o && rnd_o == 5'(r + 1), "R5 advance",
                64'(rnd_o), 64'(r + 1));
      end

      // R6: finished, ignores further acknowledgements
      chk(!rc_valid_o && rnd_o == 5'd23, "R6 end", 64'(rnd_o), 64'd23);
      repeat (4) begin
         pulse_ack();
         repeat (3) tick();
      end
      chk(!rc_valid_o, "R6 stays idle", 64'(rc_valid_o), 64'd0);
      chk(rc_o == '0 && rnd_o == 5'd23, "R6 outputs", 64'(rnd_o), 64'd23);

      // R7: start and ack together on a shown constant
      pulse_start();
      for (int r = 0; r < 3; r++) begin
         wait_valid(n);
         if (r < 2) pulse_ack();
      end
      chk(rc_o == gold(2), "R7 pre round 2", rc_o, gold(2));
      start_i = 1'b1;
      ack_i   = 1'b1;
      tick();
      start_i = 1'b0;
      ack_i   = 1'b0;
      chk(!rc_valid_o && rnd_o == 5'd0, "R7 start beats ack", 64'(rnd_o), 64'd0);
      wait_valid(n);
      chk(n == 7, "R7 latency", 64'(n), 64'd7);
      chk(rc_o == gold(0), "R7 round 0 again", rc_o, gold(0));
      pulse_ack();
      wait_valid(n);
      chk(rc_o == gold(1), "R7 continues", rc_o, gold(1));

      // R7: start in the middle of a fill
      pulse_ack();
      repeat (3) tick();
      pulse_start();
      wait_valid(n);
      chk(n == 7 && rnd_o == 0, "R7 mid-fill restart", 64'(n), 64'd7);
      chk(rc_o == gold(0), "R7 mid-fill value", rc_o, gold(0));

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
      $finish;
   end
endmodule